// File: doc/BRIEF.md
# Addressed Trigger Pulse Detector

This block sits on the receive side of a slave that shares one active-low, open-drain line with other slaves and a single master. The master pulls the line low for a time that selects one slave. The detector synchronizes and filters the line. It measures each low pulse in unit-time ticks from its own prescaler. It then decides whether the pulse falls inside the acceptance window for the slave number read from two strap inputs. When a pulse is accepted, the detector strobes the start of a new measurement sample. At the configured total trigger time it strobes the transmitter to launch its frame.

Pulses that are too short are dropped at once. Pulses that run past the window make the block sit out until a recovery time after release. After a frame, the block stays deaf until a fixed lockout has elapsed from the moment the transmitter reports that its end pulse has fallen. A trim input selects one of four unit times.

The control is a single state machine. ST_IDLE waits for a filtered falling edge and goes to ST_MEASURE. ST_MEASURE counts unit times while the line is low. From there it goes to ST_IDLE on a short release, to ST_WAIT_LAUNCH on an in-window release, to ST_OVERLONG when the count passes the window maximum, or straight to ST_RECOVER if release and overrun coincide. ST_WAIT_LAUNCH goes to ST_FRAME when the total trigger time is reached. ST_FRAME goes to ST_LOCKOUT when the transmitter reports the end pulse. ST_LOCKOUT goes to ST_IDLE after 90 µs. ST_OVERLONG goes to ST_RECOVER on release, and ST_RECOVER goes to ST_IDLE after 30 µs.

Top module: `addr_trigger_detect`

## Requirements
- R1: After reset, ready_o is 1 and sample_start_o and launch_o are 0.
- R2: The line passes through two synchronizer flops. A level change is accepted only after two consecutive equal samples, so a one-clock spike inside a low pulse does not split the measurement.
- R3: The unit time is 6, 5, 4 or 3 half-microseconds for trim_i values 0, 1, 2 and 3. A half-microsecond is CLK_PER_HALF_US clocks.
- R4: The slave number has strap_lo_i as bit 0 and strap_hi_i as bit 1. The accepted low time, in whole unit times, is 8..14 for slave 0, 16..27 for slave 1, 29..48 for slave 2 and 50..81 for slave 3.
- R5: A low pulse shorter than the slave's minimum produces no strobe, and ready_o returns to 1 within a few clocks of release.
- R6: A low pulse longer than the slave's maximum produces no strobe. ready_o stays 0 until 30 µs after the release.
- R7: With relative_mode_i = 0, launch_o pulses 90 unit times after the falling edge.
- R8: With relative_mode_i = 1, launch_o pulses at the measured low time plus 12 unit times after the falling edge.
- R9: An accepted pulse gives exactly one one-clock sample_start_o at its release, followed by exactly one one-clock launch_o. The two never coincide.
- R10: From launch_o onwards, ready_o is 0. It returns to 1 90 µs after frame_done_i is seen.
- R11: A falling edge that arrives while ready_o is 0 is never accepted. A pulse already low when the lockout ends must be released and started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw level of the shared trigger line, low = asserted |
| strap_lo_i | input | 1 | Slave number bit 0 |
| strap_hi_i | input | 1 | Slave number bit 1 |
| trim_i | input | 2 | Unit-time selection |
| relative_mode_i | input | 1 | 0: fixed total trigger time, 1: low time plus 12 units |
| frame_done_i | input | 1 | Transmitter pulse: falling edge of the end pulse sent |
| ready_o | output | 1 | Block will accept a new trigger |
| sample_start_o | output | 1 | One-clock strobe: start a new measurement sample |
| launch_o | output | 1 | One-clock strobe: start transmitting the frame |

## Verification
The end of the post-frame lockout and a new falling edge from the master can fall in the same few cycles. The edge is seen in ST_LOCKOUT while the counter is expiring, so the machine then enters ST_IDLE with the line already low. The bench provokes this by pulling the line low about twenty clocks before the lockout expires and holding it for an in-window time. It judges the outcome by sample_start_o staying silent and ready_o being 1 afterwards. A second overlap, release in the very tick that the count overruns the window, is covered by the direct path from ST_MEASURE to ST_RECOVER.

// File: rtl/atd_pkg.sv
package atd_pkg;

    localparam int CNT_W = 7;

    typedef logic [CNT_W-1:0] ucnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_WAIT_LAUNCH,
        ST_FRAME,
        ST_LOCKOUT,
        ST_OVERLONG,
        ST_RECOVER
    } state_t;

    localparam ucnt_t FIXED_TOTAL = 7'd90;
    localparam ucnt_t ALT_EXTRA   = 7'd12;

    // shortest accepted low time per slave number, in unit times
    function automatic ucnt_t win_lo(input logic [1:0] id);
        ucnt_t v;
        unique case (id)
            2'd0:    v = 7'd8;
            2'd1:    v = 7'd16;
            2'd2:    v = 7'd29;
            default: v = 7'd50;
        endcase
        return v;
    endfunction

    // longest accepted low time per slave number, in unit times
    function automatic ucnt_t win_hi(input logic [1:0] id);
        ucnt_t v;
        unique case (id)
            2'd0:    v = 7'd14;
            2'd1:    v = 7'd27;
            2'd2:    v = 7'd48;
            default: v = 7'd81;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/atd_line_filter.sv
module atd_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int AGREE       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [AGREE-1:0]       hist_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= line_i;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    logic all_low;
    logic all_high;

    assign all_low  = (hist_q == '0);
    assign all_high = (&hist_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= '1;
            level_o <= 1'b1;
        end else begin
            hist_q <= {hist_q[AGREE-2:0], sync_q[SYNC_STAGES-1]};
            if (all_high) begin
                level_o <= 1'b1;
            end else if (all_low) begin
                level_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/atd_tick_gen.sv
module atd_tick_gen #(
    parameter int CLK_PER_HALF_US = 4,
    parameter int UT_BASE_HALVES  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic [1:0] trim_i,
    output logic       half_tick_o,
    output logic       ut_tick_o
);

    localparam int PW = (CLK_PER_HALF_US > 1) ? $clog2(CLK_PER_HALF_US) : 1;
    localparam int HW = $clog2(UT_BASE_HALVES + 1);

    logic [PW-1:0] pre_q;
    logic [HW-1:0] half_q;
    logic [HW-1:0] halves_per_ut;
    logic          half_wrap;

    // each trim step removes half a microsecond from the unit time
    assign halves_per_ut = HW'(UT_BASE_HALVES) - HW'(trim_i);
    assign half_tick_o   = (pre_q == PW'(CLK_PER_HALF_US - 1));
    assign half_wrap     = (half_q == halves_per_ut - HW'(1));
    assign ut_tick_o     = half_tick_o && half_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            half_q <= '0;
        end else if (restart_i) begin
            pre_q  <= '0;
            half_q <= '0;
        end else begin
            pre_q <= half_tick_o ? '0 : pre_q + PW'(1);
            if (half_tick_o) begin
                half_q <= half_wrap ? '0 : half_q + HW'(1);
            end
        end
    end

endmodule

// File: rtl/atd_window_check.sv
module atd_window_check
    import atd_pkg::*;
(
    input  logic [1:0] slave_id_i,
    input  ucnt_t      count_i,
    output logic       below_o,
    output logic       above_o
);

    ucnt_t lo_tab [4];
    ucnt_t hi_tab [4];

    generate
        for (genvar g = 0; g < 4; g++) begin : g_win
            assign lo_tab[g] = win_lo(2'(g));
            assign hi_tab[g] = win_hi(2'(g));
        end
    endgenerate

    assign below_o = (count_i < lo_tab[slave_id_i]);
    assign above_o = (count_i > hi_tab[slave_id_i]);

endmodule

// File: rtl/addr_trigger_detect.sv
module addr_trigger_detect
    import atd_pkg::*;
#(
    parameter int CLK_PER_HALF_US = 4,
    parameter int UT_BASE_HALVES  = 6,
    parameter int LOCKOUT_US      = 90,
    parameter int RECOVER_US      = 30,
    parameter int SYNC_STAGES     = 2,
    parameter int AGREE           = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       strap_lo_i,
    input  logic       strap_hi_i,
    input  logic [1:0] trim_i,
    input  logic       relative_mode_i,
    input  logic       frame_done_i,
    output logic       ready_o,
    output logic       sample_start_o,
    output logic       launch_o
);

    localparam int LOCK_HALVES    = 2 * LOCKOUT_US;
    localparam int RECOVER_HALVES = 2 * RECOVER_US;
    localparam int HOLD_W         = $clog2(LOCK_HALVES + 1);

    state_t state_q;
    state_t state_d;

    logic        line_lvl;
    logic        line_lvl_q;
    logic        fall;
    logic        rise;
    logic        half_tick;
    logic        ut_tick;
    logic        restart;
    logic        below;
    logic        above;
    logic        launch_due;
    logic        lock_done;
    logic        recover_done;

    ucnt_t       ut_cnt_q;
    ucnt_t       meas_q;
    ucnt_t       target;
    logic [HOLD_W-1:0] hold_q;
    logic [1:0]  id_q;
    logic [1:0]  trim_q;
    logic        rel_q;

    atd_line_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .AGREE       (AGREE)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .level_o (line_lvl)
    );

    atd_tick_gen #(
        .CLK_PER_HALF_US (CLK_PER_HALF_US),
        .UT_BASE_HALVES  (UT_BASE_HALVES)
    ) u_ticks (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .trim_i      (trim_q),
        .half_tick_o (half_tick),
        .ut_tick_o   (ut_tick)
    );

    atd_window_check u_window (
        .slave_id_i (id_q),
        .count_i    (ut_cnt_q),
        .below_o    (below),
        .above_o    (above)
    );

    assign fall = line_lvl_q && !line_lvl;
    assign rise = !line_lvl_q && line_lvl;

    assign target       = rel_q ? (meas_q + ALT_EXTRA) : FIXED_TOTAL;
    assign launch_due   = ut_tick && ((ut_cnt_q + CNT_W'(1)) == target);
    assign lock_done    = half_tick && (hold_q == HOLD_W'(LOCK_HALVES - 1));
    assign recover_done = half_tick && (hold_q == HOLD_W'(RECOVER_HALVES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (above) begin
                    state_d = rise ? ST_RECOVER : ST_OVERLONG;
                end else if (rise) begin
                    state_d = below ? ST_IDLE : ST_WAIT_LAUNCH;
                end
            end
            ST_WAIT_LAUNCH: begin
                if (launch_due) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (frame_done_i) state_d = ST_LOCKOUT;
            end
            ST_LOCKOUT: begin
                if (lock_done) state_d = ST_IDLE;
            end
            ST_OVERLONG: begin
                if (rise) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (recover_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // the prescaler realigns whenever a timed state is entered
    assign restart = (state_d != state_q) &&
                     ((state_d == ST_MEASURE) || (state_d == ST_LOCKOUT) ||
                      (state_d == ST_RECOVER));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath: counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_lvl_q <= 1'b1;
            ut_cnt_q   <= '0;
            meas_q     <= '0;
            hold_q     <= '0;
            id_q       <= '0;
            trim_q     <= '0;
            rel_q      <= 1'b0;
        end else begin
            line_lvl_q <= line_lvl;

            if (state_q == ST_IDLE && fall) begin
                id_q   <= {strap_hi_i, strap_lo_i};
                trim_q <= trim_i;
                rel_q  <= relative_mode_i;
            end

            if (restart) begin
                ut_cnt_q <= '0;
            end else if (ut_tick && ut_cnt_q != '1 &&
                         (state_q == ST_MEASURE || state_q == ST_WAIT_LAUNCH)) begin
                ut_cnt_q <= ut_cnt_q + CNT_W'(1);
            end

            if (state_q == ST_MEASURE && state_d == ST_WAIT_LAUNCH) begin
                meas_q <= ut_cnt_q;
            end

            if (state_d != state_q) begin
                hold_q <= '0;
            end else if (half_tick &&
                         (state_q == ST_LOCKOUT || state_q == ST_RECOVER)) begin
                hold_q <= hold_q + HOLD_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_o        <= 1'b1;
            sample_start_o <= 1'b0;
            launch_o       <= 1'b0;
        end else begin
            ready_o        <= (state_d == ST_IDLE);
            sample_start_o <= (state_q == ST_MEASURE) && (state_d == ST_WAIT_LAUNCH);
            launch_o       <= (state_q == ST_WAIT_LAUNCH) && (state_d == ST_FRAME);
        end
    end

endmodule

// File: rtl/atd_checker.sv
module atd_checker (
    input logic clk,
    input logic rst_n,
    input logic ready_o,
    input logic sample_start_o,
    input logic launch_o
);

    // R9: sample strobe lasts one clock
    a_r9_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start_o |=> !sample_start_o);

    // R9: launch strobe lasts one clock
    a_r9_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);

    // R9: both strobes never in the same cycle
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_o && sample_start_o));

    // R10: not ready while launching
    a_r10_busy_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> !ready_o);

    // R11: an accepted trigger leaves the block not ready
    a_r11_busy_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start_o |-> !ready_o);

    // R10: after a launch, ready stays low the next cycle too
    a_r10_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !ready_o);

endmodule

bind addr_trigger_detect atd_checker u_atd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready_o        (ready_o),
    .sample_start_o (sample_start_o),
    .launch_o       (launch_o)
);

// File: tb/addr_trigger_detect_bench.sv
module addr_trigger_detect_bench;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic       strap_lo_i = 1'b0;
    logic       strap_hi_i = 1'b0;
    logic [1:0] trim_i = 2'd0;
    logic       relative_mode_i = 1'b0;
    logic       frame_done_i = 1'b0;
    logic       ready_o;
    logic       sample_start_o;
    logic       launch_o;

    always #4 clk = ~clk;

    addr_trigger_detect u_addr_trigger_detect (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_i          (line_i),
        .strap_lo_i      (strap_lo_i),
        .strap_hi_i      (strap_hi_i),
        .trim_i          (trim_i),
        .relative_mode_i (relative_mode_i),
        .frame_done_i    (frame_done_i),
        .ready_o         (ready_o),
        .sample_start_o  (sample_start_o),
        .launch_o        (launch_o)
    );

    int cyc = 0;
    int sample_n = 0;
    int launch_n = 0;
    int launch_cyc = 0;
    int checks = 0;
    int errors = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sample_start_o) sample_n <= sample_n + 1;
        if (launch_o) begin
            launch_n   <= launch_n + 1;
            launch_cyc <= cyc;
        end
    end

    // kind: 0 accepted, 1 too short, 2 too long
    typedef struct packed {
        logic [1:0] trim;
        logic [1:0] sid;
        logic       rel;
        logic [6:0] units;
        logic [1:0] kind;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 2'd0, 1'b0, 7'd10, 2'd0},
        '{2'd1, 2'd1, 1'b1, 7'd20, 2'd0},
        '{2'd2, 2'd2, 1'b0, 7'd40, 2'd0},
        '{2'd3, 2'd3, 1'b1, 7'd60, 2'd0},
        '{2'd0, 2'd0, 1'b1, 7'd8,  2'd0},
        '{2'd0, 2'd0, 1'b0, 7'd14, 2'd0},
        '{2'd3, 2'd1, 1'b0, 7'd16, 2'd0},
        '{2'd2, 2'd3, 1'b1, 7'd81, 2'd0},
        '{2'd0, 2'd2, 1'b0, 7'd20, 2'd1},
        '{2'd1, 2'd0, 1'b0, 7'd7,  2'd1},
        '{2'd2, 2'd1, 1'b1, 7'd28, 2'd2},
        '{2'd3, 2'd2, 1'b0, 7'd49, 2'd2}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ut_clks(input logic [1:0] trim);
        return (6 - int'(trim)) * HALF;
    endfunction

    task automatic finish_frame();
        frame_done_i = 1'b1;
        step(1);
        frame_done_i = 1'b0;
        step(180 * HALF - 20);
        check(ready_o == 1'b0, "R10 lockout holds", int'(ready_o), 0);
        step(40);
        check(ready_o == 1'b1, "R10 ready after lockout", int'(ready_o), 1);
    endtask

    task automatic run_vec(input vec_t v);
        int ut;
        int s0;
        int l0;
        int fall_cyc;
        int tgt;
        int elapsed;
        int d;
        ut = ut_clks(v.trim);
        trim_i = v.trim;
        strap_lo_i = v.sid[0];
        strap_hi_i = v.sid[1];
        relative_mode_i = v.rel;
        step(2);
        s0 = sample_n;
        l0 = launch_n;
        line_i = 1'b0;
        fall_cyc = cyc;
        elapsed = int'(v.units) * ut + ut / 2;
        step(elapsed);
        line_i = 1'b1;
        if (v.kind == 2'd0) begin
            tgt = v.rel ? int'(v.units) + 12 : 90;
            step(tgt * ut + 20 - elapsed);
            check(sample_n == s0 + 1, "R9 R4 one sample strobe", sample_n - s0, 1);
            check(launch_n == l0 + 1, "R9 R4 one launch strobe", launch_n - l0, 1);
            d = launch_cyc - fall_cyc - tgt * ut;
            // R3 R7 R8: launch time in unit times of the selected trim
            check(d >= 0 && d <= 14, v.rel ? "R8 R3 launch time" : "R7 R3 launch time",
                  launch_cyc - fall_cyc, tgt * ut);
            finish_frame();
        end else if (v.kind == 2'd1) begin
            step(15);
            check(ready_o == 1'b1, "R5 short pulse re-arms", int'(ready_o), 1);
            check(sample_n == s0 && launch_n == l0, "R5 short pulse ignored",
                  sample_n - s0 + launch_n - l0, 0);
        end else begin
            step(60 * HALF - 20);
            check(ready_o == 1'b0, "R6 recovery holds", int'(ready_o), 0);
            step(40);
            check(ready_o == 1'b1, "R6 ready after recovery", int'(ready_o), 1);
            check(sample_n == s0 && launch_n == l0, "R6 long pulse ignored",
                  sample_n - s0 + launch_n - l0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        int l0;
        int fc;
        step(3);
        rst_n = 1'b1;
        step(3);
        // R1 reset state
        check(ready_o == 1'b1, "R1 ready after reset", int'(ready_o), 1);
        check(sample_n == 0 && launch_n == 0, "R1 no strobes after reset",
              sample_n + launch_n, 0);

        for (int i = 0; i < 12; i++) begin
            run_vec(VECS[i]);
        end

        // R2: one-clock spike inside a 10-unit pulse, slave 0, trim 0
        trim_i = 2'd0;
        strap_lo_i = 1'b0;
        strap_hi_i = 1'b0;
        relative_mode_i = 1'b0;
        step(2);
        s0 = sample_n;
        l0 = launch_n;
        line_i = 1'b0;
        fc = cyc;
        step(5 * 24);
        line_i = 1'b1;
        step(1);
        line_i = 1'b0;
        step(5 * 24 + 11);
        line_i = 1'b1;
        step(90 * 24 - 10 * 24);
        check(sample_n == s0 + 1, "R2 spike filtered, sample", sample_n - s0, 1);
        check(launch_n == l0 + 1 && (launch_cyc - fc - 90 * 24) <= 14,
              "R2 spike filtered, launch", launch_cyc - fc, 90 * 24);
        // R11: new fall just before the lockout ends
        frame_done_i = 1'b1;
        step(1);
        frame_done_i = 1'b0;
        step(180 * HALF - 20);
        s0 = sample_n;
        line_i = 1'b0;
        step(10 * 24 + 12);
        line_i = 1'b1;
        step(100 * 24);
        check(sample_n == s0, "R11 fall during lockout ignored", sample_n - s0, 0);
        check(ready_o == 1'b1, "R11 ready after ignored pulse", int'(ready_o), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule